// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block takes the two open-collector lines of a PS/2 keyboard and turns each serial frame into one parallel byte. The keyboard drives the clock and data lines; the block samples both with the fast system clock, synchronises them and filters the keyboard clock. On every filtered falling edge it shifts in one frame bit. A frame is eleven bits: a start bit of 0, eight data bits with the least significant bit first, an odd parity bit and a stop bit of 1.

When a frame passes its checks, the data byte is placed on the scan code output and the ready flag is set. The flag stays set until the consumer pulses the read input, so each byte is taken exactly once. Multi-byte key sequences, such as a release prefix followed by a make code, or a stream of repeated make codes from a held key, arrive as separate bytes, each with its own ready event. A frame with a wrong start, stop or parity bit is dropped. A frame left unfinished for longer than an idle limit is abandoned, so the next start bit is framed correctly.

Top module: `ps2_scan_rx`

## Requirements
- R1: While rst_ni is low and after its release, scan_ready_o is 0 and scan_code_o is 8'h00. Reset also clears any partly received frame, so a full frame sent after a reset in mid-frame is decoded correctly.
- R2: A frame is eleven bits, one per falling edge of the filtered keyboard clock: start bit 0, data bits 0 through 7, odd parity over the data, stop bit 1. The data byte of a valid frame appears on scan_code_o.
- R3: scan_ready_o rises only after a valid frame has completed, and it stays high until a read clears it.
- R4: A one-cycle pulse on read_i clears scan_ready_o on the next clock edge and leaves scan_code_o unchanged. A read in the same cycle that a new byte completes leaves the flag set.
- R5: A frame whose parity bit makes the count of ones in data plus parity even is discarded: scan_ready_o stays 0 and scan_code_o keeps its previous value.
- R6: A frame with a start bit of 1 or a stop bit of 0 is discarded in the same way, and the frame after it is received normally.
- R7: Each byte of a multi-byte sequence (release prefix 8'hF0 then a make code, or the same make code repeated) is delivered as its own byte with its own ready event.
- R8: A low pulse on the keyboard clock shorter than FILT_LEN system cycles is not counted as an edge and does not disturb the frame in progress.
- R9: If no keyboard clock falling edge arrives for IDLE_CYCLES system cycles while a frame is partly received, the bit counter returns to zero and the next frame is decoded correctly.
- R10: A valid byte that completes while scan_ready_o is still high replaces scan_code_o, and scan_ready_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kbd_clk_i | input | 1 | Keyboard clock line |
| kbd_data_i | input | 1 | Keyboard data line |
| read_i | input | 1 | Consumer has taken the byte; clears the ready flag |
| scan_code_o | output | 8 | Last valid received byte |
| scan_ready_o | output | 1 | A byte is waiting to be read |

## Verification
A falling keyboard clock edge reaches the frame logic after the synchroniser depth plus FILT_LEN plus two system cycles. A completed frame then sets the outputs one cycle later, so the byte is due no more than about ten cycles after the stop bit's falling edge. The bench holds every keyboard clock phase for twelve system cycles and samples the outputs 30 cycles after the stop bit's clock rises, which is well past that latency. A read takes effect on the next clock edge, so the bench checks the flag one full cycle after the pulse. All samples are taken on the falling system clock edge, away from the edge where the outputs change.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned FRAME_BITS = 11;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);

  typedef logic [7:0]            byte_t;
  typedef logic [FRAME_BITS-1:0] frame_t;
  typedef logic [CNT_W-1:0]      bit_cnt_t;

  // frame bit 0 = start, 8:1 = data, 9 = parity, 10 = stop
  function automatic logic frame_ok(frame_t f);
    return (f[0] == 1'b0) && (f[FRAME_BITS-1] == 1'b1) && (^f[9:1] == 1'b1);
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kbd_clk_i,
  input  logic kbd_data_i,
  output logic data_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] clk_sync, dat_sync;
  logic [FILT_LEN-1:0]    hist;
  logic                   filt_q, filt_d1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync <= '1;
      dat_sync <= '1;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], kbd_clk_i};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], kbd_data_i};
    end
  end

  generate
    if (FILT_LEN > 1) begin : g_hist
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist <= '1;
        else         hist <= {hist[FILT_LEN-2:0], clk_sync[SYNC_STAGES-1]};
      end
    end else begin : g_hist1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist <= '1;
        else         hist <= clk_sync[SYNC_STAGES-1];
      end
    end
  endgenerate

  // filtered level changes only when the whole window agrees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q  <= 1'b1;
      filt_d1 <= 1'b1;
    end else begin
      if (&hist)       filt_q <= 1'b1;
      else if (~|hist) filt_q <= 1'b0;
      filt_d1 <= filt_q;
    end
  end

  assign fall_o = filt_d1 & ~filt_q;
  assign data_o = dat_sync[SYNC_STAGES-1];
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 10000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     fall_i,
  input  logic     data_i,
  output byte_t    byte_o,
  output logic     byte_vld_o,
  output bit_cnt_t bit_cnt_o,
  output logic     tmo_hit_o
);
  localparam int unsigned IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam bit_cnt_t    LAST   = bit_cnt_t'(FRAME_BITS - 1);

  frame_t            frm_q, frm_nxt;
  bit_cnt_t          cnt_q;
  logic [IDLE_W-1:0] idle_q;

  assign frm_nxt   = {data_i, frm_q[FRAME_BITS-1:1]};
  assign tmo_hit_o = (cnt_q != '0) && !fall_i &&
                     (idle_q == IDLE_W'(IDLE_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (cnt_q == '0 || fall_i || tmo_hit_o) begin
      idle_q <= '0;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      frm_q <= '0;
    end else if (fall_i) begin
      frm_q <= frm_nxt;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end else if (tmo_hit_o) begin
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= fall_i && (cnt_q == LAST) && frame_ok(frm_nxt);
      if (fall_i && cnt_q == LAST) byte_o <= frm_nxt[8:1];
    end
  end

  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/ps2_code_hold.sv
module ps2_code_hold
  import ps2_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  byte_t byte_i,
  input  logic  byte_vld_i,
  input  logic  read_i,
  output byte_t scan_code_o,
  output logic  scan_ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_code_o  <= '0;
      scan_ready_o <= 1'b0;
    end else if (byte_vld_i) begin
      scan_code_o  <= byte_i;
      scan_ready_o <= 1'b1;
    end else if (read_i) begin
      scan_ready_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2_scan_rx.sv
module ps2_scan_rx
  import ps2_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned IDLE_CYCLES = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kbd_clk_i,
  input  logic       kbd_data_i,
  input  logic       read_i,
  output logic [7:0] scan_code_o,
  output logic       scan_ready_o
);
  logic     data_s, fall_s, byte_vld, tmo_hit;
  byte_t    byte_s;
  bit_cnt_t bit_cnt;

  ps2_line_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kbd_clk_i (kbd_clk_i),
    .kbd_data_i(kbd_data_i),
    .data_o    (data_s),
    .fall_o    (fall_s)
  );

  ps2_frame_rx #(
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall_s),
    .data_i    (data_s),
    .byte_o    (byte_s),
    .byte_vld_o(byte_vld),
    .bit_cnt_o (bit_cnt),
    .tmo_hit_o (tmo_hit)
  );

  ps2_code_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (byte_s),
    .byte_vld_i  (byte_vld),
    .read_i      (read_i),
    .scan_code_o (scan_code_o),
    .scan_ready_o(scan_ready_o)
  );
endmodule

// File: rtl/ps2_scan_rx_chk.sv
module ps2_scan_rx_chk
  import ps2_rx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       read_i,
  input logic [7:0] scan_code_o,
  input logic       scan_ready_o,
  input logic       byte_vld,
  input bit_cnt_t   bit_cnt,
  input logic       tmo_hit
);
  assert_rise_needs_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scan_ready_o) |-> $past(byte_vld));

  assert_ready_after_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld |=> scan_ready_o);

  assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !byte_vld) |=> !scan_ready_o);

  assert_code_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld |=> $stable(scan_code_o));

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= bit_cnt_t'(FRAME_BITS - 1));

  assert_timeout_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_hit |=> (bit_cnt == '0));
endmodule

bind ps2_scan_rx ps2_scan_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .read_i      (read_i),
  .scan_code_o (scan_code_o),
  .scan_ready_o(scan_ready_o),
  .byte_vld    (byte_vld),
  .bit_cnt     (bit_cnt),
  .tmo_hit     (tmo_hit)
);

// File: tb/ps2_scan_rx_tb_top.sv
module ps2_scan_rx_tb_top;
  localparam int HALF  = 12;
  localparam int IDLE  = 200;
  localparam int FILT  = 4;
  localparam int LIMIT = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kclk = 1'b1;
  logic       kdat = 1'b1;
  logic       rd = 1'b0;
  logic [7:0] code;
  logic       rdy;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ps2_scan_rx #(.SYNC_STAGES(2), .FILT_LEN(FILT), .IDLE_CYCLES(IDLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .kbd_clk_i(kclk), .kbd_data_i(kdat),
    .read_i(rd), .scan_code_o(code), .scan_ready_o(rdy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= LIMIT && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    kdat = b;
    wait_cyc(HALF);
    kclk = 1'b0;
    wait_cyc(HALF);
    kclk = 1'b1;
  endtask

  // flip: bit0 start, bit1 parity, bit2 stop; glitch inserts short lows
  task automatic send_frame(logic [7:0] b, logic [2:0] flip, bit glitch);
    send_bit(1'b0 ^ flip[0]);
    for (int i = 0; i < 8; i++) begin
      if (glitch) begin
        wait_cyc(3);
        kclk = 1'b0;
        wait_cyc(FILT - 2);
        kclk = 1'b1;
      end
      send_bit(b[i]);
    end
    send_bit((~^b) ^ flip[1]);
    send_bit(1'b1 ^ flip[2]);
    kdat = 1'b1;
    wait_cyc(30);
  endtask

  task automatic do_read();
    rd = 1'b1;
    wait_cyc(1);
    rd = 1'b0;
    wait_cyc(1);
  endtask

  task automatic expect_byte(logic [7:0] b, string req);
    chk(rdy === 1'b1, req, rdy, 1);
    chk(code === b, req, code, b);
  endtask

  initial begin
    wait_cyc(3);
    chk(rdy === 1'b0, "R1", rdy, 0);
    chk(code === 8'h00, "R1", code, 0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk(rdy === 1'b0 && code === 8'h00, "R1", {rdy, code}, 0);

    // R2 R3 R4: every data byte
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 3'b000, 1'b0);
      expect_byte(8'(v), "R2");
      do_read();
      chk(rdy === 1'b0, "R4", rdy, 0);
      chk(code === 8'(v), "R4", code, v);
    end

    // R3: ready holds without read
    send_frame(8'h3C, 3'b000, 1'b0);
    wait_cyc(100);
    expect_byte(8'h3C, "R3");
    do_read();

    // R5: bad parity
    send_frame(8'h77, 3'b010, 1'b0);
    chk(rdy === 1'b0, "R5", rdy, 0);
    chk(code === 8'h3C, "R5", code, 8'h3C);
    // R6: bad start, bad stop, then recovery
    send_frame(8'h11, 3'b001, 1'b0);
    chk(rdy === 1'b0 && code === 8'h3C, "R6", {rdy, code}, {1'b0, 8'h3C});
    send_frame(8'h22, 3'b100, 1'b0);
    chk(rdy === 1'b0 && code === 8'h3C, "R6", {rdy, code}, {1'b0, 8'h3C});
    send_frame(8'h4B, 3'b000, 1'b0);
    expect_byte(8'h4B, "R6");
    do_read();

    // R7: release sequence and repeated make codes
    send_frame(8'hF0, 3'b000, 1'b0);
    expect_byte(8'hF0, "R7");
    do_read();
    chk(rdy === 1'b0, "R7", rdy, 0);
    send_frame(8'h1C, 3'b000, 1'b0);
    expect_byte(8'h1C, "R7");
    do_read();
    for (int k = 0; k < 3; k++) begin
      send_frame(8'h1C, 3'b000, 1'b0);
      expect_byte(8'h1C, "R7");
      do_read();
      chk(rdy === 1'b0, "R7", rdy, 0);
    end

    // R10: overwrite while ready set
    send_frame(8'hA5, 3'b000, 1'b0);
    send_frame(8'h5A, 3'b000, 1'b0);
    expect_byte(8'h5A, "R10");
    do_read();

    // R8: short lows on the keyboard clock
    send_frame(8'h96, 3'b000, 1'b1);
    expect_byte(8'h96, "R8");
    do_read();

    // R9: abandoned partial frame
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    kdat = 1'b1;
    wait_cyc(IDLE + 100);
    chk(rdy === 1'b0, "R9", rdy, 0);
    send_frame(8'h6D, 3'b000, 1'b0);
    expect_byte(8'h6D, "R9");
    do_read();

    // R1: reset in mid-frame
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_frame(8'h00, 3'b000, 1'b0);
    rst_n = 1'b0;
    wait_cyc(3);
    chk(rdy === 1'b0 && code === 8'h00, "R1", {rdy, code}, 0);
    rst_n = 1'b1;
    wait_cyc(3);
    send_bit(1'b0);
    send_bit(1'b1);
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(3);
    send_frame(8'hC3, 3'b000, 1'b0);
    expect_byte(8'hC3, "R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule